// File: doc/BRIEF.md
# Configuration Store with Security Lock

This block holds the configuration pattern of a small programmable logic fabric: a set of words that together form the fuse map and the per-output mode bits. A programmer drives it through a narrow command port (a strobe, a two-bit command code, a word address and a data word). Four commands exist: bulk erase, word program, word read and security lock. The block presents the whole pattern to the logic fabric as one flat vector. It also drives a flag that says whether test preload of the fabric's registers is allowed.

Each bit has two states. An erased bit holds 1 and a programmed bit holds 0. Programming can only pull bits from 1 to 0, and only an erase returns them to 1. A programming session starts with an automatic bulk erase of the whole array, so the programmer never needs to issue a separate erase before writing a new pattern. Setting the lock makes every read return the blank value and withdraws preload permission. The lock falls only when a complete erase of the whole array finishes, so a protected pattern can never be read or preloaded while it still exists.

The flat configuration vector is a snapshot. It is refreshed in a single step at the end of each command that modifies the array, so the fabric never sees a partly written word or a partly erased array.

Top module: `cfg_store_lock`

## Requirements
- R1: After reset the array is blank. `cfg_o` is all ones, `secure_o` is 0, `preload_ok_o` is 1, and `busy_o` and `rvalid_o` are 0.
- R2: Command codes are 0 = erase, 1 = program word, 2 = read word and 3 = lock. A strobe is accepted only while `busy_o` is low. A strobe given while busy has no effect on the array, on `rvalid_o` or on the lock.
- R3: A read accepted at a clock edge raises `rvalid_o` for one cycle after that edge. While unlocked, `rdata_o` then holds the stored word, in which programmed bits read 0 and erased bits read 1.
- R4: Within a session, a program command replaces the addressed word with the bitwise AND of the old word and `wdata_i`. No bit ever goes from 0 to 1 through a program command.
- R5: The first program command after reset or after a lock command first erases the whole array, which also clears the lock. It then writes its word, so the resulting array holds only that word's programmed bits.
- R6: An erase command writes all ones to every word, one word per cycle. `busy_o` stays high for 2^ADDR_W + 1 cycles after the accepting edge.
- R7: While `secure_o` is 1, every read returns all ones regardless of the stored contents.
- R8: `preload_ok_o` is low exactly while the lock is set.
- R9: The lock, once set, stays set through reads and further lock commands. It clears only at the end of a full-array erase, whether that erase is explicit or automatic.
- R10: Word w of the array appears on `cfg_o[w*DATA_W +: DATA_W]`. `cfg_o` changes only on the final cycle of a modifying command, and then equals the whole array. Locking does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, one command per cycle high |
| cmd_i | input | 2 | Command code |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Program data, 0 bits get programmed |
| busy_o | output | 1 | A multi-cycle command is in progress |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | DATA_W | Read data |
| cfg_o | output | 2^ADDR_W*DATA_W | Live configuration snapshot |
| secure_o | output | 1 | Security lock state |
| preload_ok_o | output | 1 | Register preload permitted |

## Verification
The bench goes after the lock's boundaries. A read right after locking must return ones even though the snapshot still holds the true pattern; a design that masks only `cfg_o` or leaks the stored word would fail here. A program issued after locking must wipe the old pattern before it writes; a design that drops the lock without erasing would expose the old words on the next read. A program on top of existing data must give the AND of the two words, which catches an overwrite in place of the AND. A strobe issued during the erase sweep must leave no trace, which catches a sequencer that accepts commands while busy. The sweep length is counted in cycles, and a random command stream is compared with a reference model after every command.

// File: rtl/cfg_store_pkg.sv
package cfg_store_pkg;
  typedef enum logic [1:0] {
    CMD_ERASE = 2'd0,
    CMD_PROG  = 2'd1,
    CMD_READ  = 2'd2,
    CMD_LOCK  = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SWEEP,
    ST_WRITE,
    ST_COMMIT
  } seq_st_e;
endpackage

// File: rtl/cfg_array.sv
module cfg_array #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  localparam int N_WORDS = 1 << ADDR_W,
  localparam int FLAT_W = N_WORDS * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_en_i,
  input  logic [ADDR_W-1:0] clr_addr_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [FLAT_W-1:0] flat_o
);
  logic [DATA_W-1:0] mem_q [N_WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_WORDS; i++) mem_q[i] <= '1;
    end else begin
      if (clr_en_i) mem_q[clr_addr_i] <= '1;
      // programming only pulls bits low
      if (wr_en_i) mem_q[wr_addr_i] <= mem_q[wr_addr_i] & wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

  for (genvar g = 0; g < N_WORDS; g++) begin : g_flat
    assign flat_o[g*DATA_W +: DATA_W] = mem_q[g];
  end
endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
  import cfg_store_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              clr_en_o,
  output logic [ADDR_W-1:0] clr_addr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              commit_o,
  output logic              rd_go_o,
  output logic              secure_o,
  output logic              busy_o
);
  localparam logic [ADDR_W-1:0] LAST_WORD = '1;

  seq_st_e           state_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              pend_q;
  logic              sess_q;
  logic              secure_q;
  logic              accept;
  cmd_e              cmd;

  assign cmd    = cmd_e'(cmd_i);
  assign accept = cmd_valid_i && (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      ptr_q    <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      pend_q   <= 1'b0;
      sess_q   <= 1'b0;
      secure_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          unique case (cmd)
            CMD_ERASE: begin
              state_q <= ST_SWEEP;
              ptr_q   <= '0;
              pend_q  <= 1'b0;
            end
            CMD_PROG: begin
              addr_q <= addr_i;
              data_q <= wdata_i;
              if (sess_q) begin
                state_q <= ST_WRITE;
              end else begin
                // new session: blank the array first
                state_q <= ST_SWEEP;
                ptr_q   <= '0;
                pend_q  <= 1'b1;
              end
            end
            CMD_LOCK: begin
              secure_q <= 1'b1;
              sess_q   <= 1'b0;
            end
            default: ;
          endcase
        end
        ST_SWEEP: begin
          ptr_q <= ptr_q + 1'b1;
          if (ptr_q == LAST_WORD) begin
            secure_q <= 1'b0;
            sess_q   <= 1'b1;
            state_q  <= pend_q ? ST_WRITE : ST_COMMIT;
          end
        end
        ST_WRITE:  state_q <= ST_COMMIT;
        ST_COMMIT: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign clr_en_o   = (state_q == ST_SWEEP);
  assign clr_addr_o = ptr_q;
  assign wr_en_o    = (state_q == ST_WRITE);
  assign wr_addr_o  = addr_q;
  assign wr_data_o  = data_q;
  assign commit_o   = (state_q == ST_COMMIT);
  assign rd_go_o    = accept && (cmd == CMD_READ);
  assign secure_o   = secure_q;
  assign busy_o     = (state_q != ST_IDLE);
endmodule

// File: rtl/cfg_shadow.sv
module cfg_shadow #(
  parameter int FLAT_W = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [FLAT_W-1:0] flat_i,
  output logic [FLAT_W-1:0] cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_o <= '1;
    else if (commit_i) cfg_o <= flat_i;
  end
endmodule

// File: rtl/cfg_store_lock.sv
module cfg_store_lock #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  localparam int N_WORDS = 1 << ADDR_W,
  localparam int FLAT_W = N_WORDS * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [FLAT_W-1:0] cfg_o,
  output logic              secure_o,
  output logic              preload_ok_o
);
  logic              clr_en, wr_en, commit, rd_go;
  logic [ADDR_W-1:0] clr_addr, wr_addr;
  logic [DATA_W-1:0] wr_data, rd_word;
  logic [FLAT_W-1:0] flat;

  cfg_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) seq_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_i       (cmd_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .clr_en_o    (clr_en),
    .clr_addr_o  (clr_addr),
    .wr_en_o     (wr_en),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data),
    .commit_o    (commit),
    .rd_go_o     (rd_go),
    .secure_o    (secure_o),
    .busy_o      (busy_o)
  );

  cfg_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) array_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_en_i   (clr_en),
    .clr_addr_i (clr_addr),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .rd_addr_i  (addr_i),
    .rd_data_o  (rd_word),
    .flat_o     (flat)
  );

  cfg_shadow #(.FLAT_W(FLAT_W)) shadow_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit),
    .flat_i   (flat),
    .cfg_o    (cfg_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '1;
    end else begin
      rvalid_o <= rd_go;
      // locked parts read blank
      if (rd_go) rdata_o <= secure_o ? '1 : rd_word;
    end
  end

  assign preload_ok_o = ~secure_o;
endmodule

// File: rtl/cfg_store_lock_chk.sv
module cfg_store_lock_chk
  import cfg_store_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  localparam int FLAT_W = (1 << ADDR_W) * DATA_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [1:0]        cmd_i,
  input logic              busy_o,
  input logic              rvalid_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic [FLAT_W-1:0] cfg_o,
  input logic              secure_o
);
  a_r7_locked_read_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && secure_o) |-> (rdata_o == '1));

  a_r9_unlock_in_sweep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(secure_o) |-> busy_o);

  a_r10_cfg_at_completion: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_o) |-> (!busy_o && $past(busy_o)));

  a_r3_rvalid_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(cmd_valid_i && !busy_o && cmd_i == CMD_READ));

  a_r2_busy_needs_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cmd_valid_i));

  a_r9_lock_needs_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(secure_o) |-> $past(cmd_valid_i && !busy_o && cmd_i == CMD_LOCK));
endmodule

bind cfg_store_lock cfg_store_lock_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_i       (cmd_i),
  .busy_o      (busy_o),
  .rvalid_o    (rvalid_o),
  .rdata_o     (rdata_o),
  .cfg_o       (cfg_o),
  .secure_o    (secure_o)
);

// File: tb/cfg_store_lock_tb_top.sv
module cfg_store_lock_tb_top;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 16;
  localparam int N_WORDS = 1 << ADDR_W;
  localparam int FLAT_W  = N_WORDS * DATA_W;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cmd_valid_i = 1'b0;
  logic [1:0]        cmd_i = '0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic              busy_o, rvalid_o, secure_o, preload_ok_o;
  logic [DATA_W-1:0] rdata_o;
  logic [FLAT_W-1:0] cfg_o;

  always #5 clk_i = ~clk_i;

  cfg_store_lock #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (.*);

  int n_chk = 0, n_fail = 0, busy_cyc;
  logic [DATA_W-1:0] mem_m [N_WORDS];
  bit secure_m, sess_m;
  logic [FLAT_W-1:0] cfg_m;

  task automatic chk(input bit ok, input string tag, input logic [FLAT_W-1:0] act,
                     input logic [FLAT_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [FLAT_W-1:0] flat_m();
    logic [FLAT_W-1:0] f;
    for (int w = 0; w < N_WORDS; w++) f[w*DATA_W +: DATA_W] = mem_m[w];
    return f;
  endfunction

  function automatic void m_erase();
    for (int w = 0; w < N_WORDS; w++) mem_m[w] = '1;
    secure_m = 0;
    sess_m = 1;
  endfunction

  // issue one command, wait for completion, update model, check outputs
  task automatic run_cmd(input logic [1:0] c, input logic [ADDR_W-1:0] a,
                         input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] exp_rd;
    exp_rd = secure_m ? '1 : mem_m[a];
    @(negedge clk_i);
    cmd_i = c; addr_i = a; wdata_i = d; cmd_valid_i = 1'b1;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    case (c)
      2'd0: begin m_erase(); cfg_m = flat_m(); end
      2'd1: begin
        if (!sess_m) m_erase();
        mem_m[a] = mem_m[a] & d;
        cfg_m = flat_m();
      end
      2'd2: begin
        chk(rvalid_o === 1'b1, "R3 rvalid", FLAT_W'(rvalid_o), 1);
        chk(rdata_o === exp_rd, secure_m ? "R7 locked read" : "R3 read data",
            FLAT_W'(rdata_o), FLAT_W'(exp_rd));
      end
      default: begin secure_m = 1; sess_m = 0; end
    endcase
    busy_cyc = 0;
    while (busy_o) begin busy_cyc++; @(negedge clk_i); end
    if (c == 2'd0) chk(busy_cyc == N_WORDS + 1, "R6 sweep length", busy_cyc, N_WORDS + 1);
    chk(cfg_o === cfg_m, "R10 cfg snapshot", cfg_o, cfg_m);
    chk(secure_o === secure_m, "R9 lock state", FLAT_W'(secure_o), FLAT_W'(secure_m));
    chk(preload_ok_o === !secure_m, "R8 preload flag", FLAT_W'(preload_ok_o), FLAT_W'(!secure_m));
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5e));
    for (int w = 0; w < N_WORDS; w++) mem_m[w] = '1;
    secure_m = 0; sess_m = 0; cfg_m = '1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(cfg_o === '1, "R1 cfg blank", cfg_o, '1);
    chk(secure_o === 0 && preload_ok_o === 1, "R1 lock/preload", FLAT_W'({secure_o, preload_ok_o}), 1);
    chk(busy_o === 0 && rvalid_o === 0, "R1 busy/rvalid", FLAT_W'({busy_o, rvalid_o}), 0);

    // R5 first program opens session with auto-erase; R3 readback
    run_cmd(2'd1, 4'd2, 16'hA5F0);
    run_cmd(2'd2, 4'd2, '0);
    // R4 AND semantics
    run_cmd(2'd1, 4'd2, 16'hFF0F);
    chk(mem_m[2] == 16'hA500, "R4 model and", FLAT_W'(mem_m[2]), 16'hA500);
    run_cmd(2'd2, 4'd2, '0);
    run_cmd(2'd1, 4'd7, 16'h0F0F);
    // R7/R8 lock: reads blank, cfg keeps pattern
    run_cmd(2'd3, '0, '0);
    run_cmd(2'd2, 4'd2, '0);
    run_cmd(2'd2, 4'd7, '0);
    run_cmd(2'd3, '0, '0);
    // R9 explicit erase clears lock, R6 sweep length
    run_cmd(2'd0, '0, '0);
    run_cmd(2'd2, 4'd2, '0);
    // R5/R9 program after lock wipes old pattern
    run_cmd(2'd1, 4'd1, 16'h1234);
    run_cmd(2'd3, '0, '0);
    run_cmd(2'd1, 4'd9, 16'h00FF);
    chk(cfg_o[1*DATA_W +: DATA_W] === '1, "R5 old word wiped",
        FLAT_W'(cfg_o[1*DATA_W +: DATA_W]), FLAT_W'(16'hFFFF));
    run_cmd(2'd2, 4'd1, '0);

    // R2 strobes during busy are ignored
    @(negedge clk_i);
    cmd_i = 2'd0; cmd_valid_i = 1'b1;
    @(negedge clk_i);
    cmd_i = 2'd1; addr_i = 4'd3; wdata_i = '0;
    @(negedge clk_i);
    cmd_i = 2'd2;
    @(negedge clk_i);
    chk(rvalid_o === 1'b0, "R2 busy read ignored", FLAT_W'(rvalid_o), 0);
    cmd_i = 2'd3;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    while (busy_o) @(negedge clk_i);
    m_erase(); cfg_m = flat_m();
    chk(cfg_o === cfg_m, "R2 busy program ignored", cfg_o, cfg_m);
    chk(secure_o === 1'b0, "R2 busy lock ignored", FLAT_W'(secure_o), 0);

    // random phase
    for (int i = 0; i < 300; i++) begin
      int r;
      logic [1:0] c;
      r = $urandom_range(0, 99);
      c = (r < 45) ? 2'd1 : (r < 85) ? 2'd2 : (r < 95) ? 2'd3 : 2'd0;
      run_cmd(c, ADDR_W'($urandom_range(0, N_WORDS - 1)), DATA_W'($urandom));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule